// File: doc/BRIEF.md
# Strobe-Sequenced Fixed-Point PI Regulator

This block is a discrete proportional-integral regulator that performs one update each time a one-cycle start pulse arrives. It can be used as the loop filter of a phase-locked angle tracker or as a speed regulator. On an accepted pulse it captures the setpoint, the measured value, both gains and the sample period. Over the following cycles it forms the error, then the proportional term and the integral increment. It then adds the increment to the running integral and combines proportional part, integral and a feedforward offset into a rescaled result, which it presents together with a one-cycle completion pulse.

The sequencer has six named states. IDLE waits for a start pulse and goes to CALC_ERR when one arrives. CALC_ERR forms the error and the period-scaled integral gain and always goes to CALC_PROD. CALC_PROD forms both products and always goes to ACCUM. ACCUM updates the integrator and always goes to EMIT. EMIT registers the result and always goes to FINISH. FINISH drives the completion pulse and always goes back to IDLE. A start pulse is acted on only in IDLE.

Formats: gains are Q10.21, the sample period is Q0.31, the error is Q11.12 (24 bits), and internal terms and the integral are 48-bit Q23.24. All arithmetic is signed two's complement. Right shifts are arithmetic and truncate toward minus infinity. Every narrowing keeps the low bits.

Top module: `pi_seq_ctrl`

## Requirements
- R1: After synchronous reset, `done` is 0 and `y_out` is 0.
- R2: Operands are captured only in the cycle whose rising edge accepts `start` in IDLE. Changing any operand input after that edge has no effect on the update's result.
- R3: The error is the low 24 bits of `setpoint - actual`, taken as a signed Q11.12 value, so that a difference outside the 24-bit range wraps.
- R4: The period-scaled integral gain is `(ki * period) >>> 21`, computed from the full 64-bit product and truncated to 32 bits (Q0.31).
- R5: The proportional term is `(kp * error) >>> 9`, truncated to 48 bits.
- R6: The integral increment is `(scaled_gain * error) >>> 19`, truncated to 48 bits. The integrator adds one increment per update and keeps its value between updates.
- R7: `y_out = (P + I + sign_extend(omega_init)) >>> 8`, summed in 48 bits and truncated to 32 bits (Q15.16). `y_out` changes only at the edge that raises `done`.
- R8: `done` goes high at the fourth rising edge after the accepting edge, stays high for exactly one cycle, and the sequencer is idle again on the next edge.
- R9: A `start` pulse that arrives while an update is in progress, including the cycle in which `done` is high, is ignored. It produces no extra `done` and no extra integration.
- R10: Synchronous reset clears the integrator to zero, so that the first update after reset integrates from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request for an update |
| setpoint | input | 32 | Reference value, signed Q11.12 |
| actual | input | 32 | Measured value, signed Q11.12 |
| kp | input | 32 | Proportional gain, signed Q10.21 |
| ki | input | 32 | Integral gain, signed Q10.21 |
| period | input | 32 | Sample period, signed Q0.31 |
| omega_init | input | 32 | Feedforward offset, signed Q23.24 |
| y_out | output | 32 | Regulator output, signed Q15.16 |
| done | output | 1 | One-cycle pulse marking a new `y_out` |

## Verification
The integrator is hidden, so its state is hardest to observe from the ports. Its history shows up only as drift in later results. The bench runs repeated updates with the same operands and compares each result with a running reference. It places extra start pulses inside a busy sequence and asserts reset between updates. A stray extra integration or a missed clear then shows up as a wrong value in the next update. Negative errors and a difference that overflows 24 bits make rounding or wrapping mistakes visible.

// File: rtl/pi_seq_pkg.sv
package pi_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALC_ERR,
        ST_CALC_PROD,
        ST_ACCUM,
        ST_EMIT,
        ST_FINISH
    } pi_state_t;

    localparam int unsigned GAIN_SHIFT = 21;
    localparam int unsigned P_SHIFT    = 9;
    localparam int unsigned I_SHIFT    = 19;
    localparam int unsigned OUT_SHIFT  = 8;

endpackage

// File: rtl/pi_seq_fsm.sv
module pi_seq_fsm
    import pi_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output pi_state_t state,
    output logic      accept,
    output logic      busy,
    output logic      en_err,
    output logic      en_prod,
    output logic      en_accum,
    output logic      en_emit,
    output logic      done
);

    pi_state_t state_q;
    pi_state_t state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_CALC_ERR;
            ST_CALC_ERR:  state_d = ST_CALC_PROD;
            ST_CALC_PROD: state_d = ST_ACCUM;
            ST_ACCUM:     state_d = ST_EMIT;
            ST_EMIT:      state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // output decode
    always_comb begin
        accept   = 1'b0;
        en_err   = 1'b0;
        en_prod  = 1'b0;
        en_accum = 1'b0;
        en_emit  = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:      accept   = start;
            ST_CALC_ERR:  en_err   = 1'b1;
            ST_CALC_PROD: en_prod  = 1'b1;
            ST_ACCUM:     en_accum = 1'b1;
            ST_EMIT:      en_emit  = 1'b1;
            ST_FINISH:    done     = 1'b1;
            default:      ;
        endcase
    end

    assign busy  = (state_q != ST_IDLE);
    assign state = state_q;

    // a start seen while a sequence runs never restarts it
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> (state_q != ST_CALC_ERR));

endmodule

// File: rtl/pi_seq_integ.sv
module pi_seq_integ #(
    parameter int unsigned ACC_W = 48
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en_accum,
    input  logic signed [ACC_W-1:0] inc,
    output logic signed [ACC_W-1:0] integ
);

    always_ff @(posedge clk) begin
        if (rst)           integ <= '0;
        else if (en_accum) integ <= integ + inc;
    end

endmodule

// File: rtl/pi_seq_datapath.sv
module pi_seq_datapath
    import pi_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ERR_W  = 24,
    parameter int unsigned ACC_W  = 48
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     accept,
    input  logic                     busy,
    input  logic                     en_err,
    input  logic                     en_prod,
    input  logic                     en_emit,
    input  logic signed [DATA_W-1:0] setpoint,
    input  logic signed [DATA_W-1:0] actual,
    input  logic signed [DATA_W-1:0] kp,
    input  logic signed [DATA_W-1:0] ki,
    input  logic signed [DATA_W-1:0] period,
    input  logic signed [DATA_W-1:0] omega_init,
    input  logic signed [ACC_W-1:0]  integ,
    output logic signed [ACC_W-1:0]  inc,
    output logic signed [DATA_W-1:0] y_out
);

    localparam int unsigned WIDE_W = 2 * DATA_W;
    localparam int unsigned PROD_W = DATA_W + ERR_W;

    // captured operands
    logic signed [DATA_W-1:0] sp_q, act_q, kp_q, ki_q, per_q, om_q;
    // intermediate terms
    logic signed [ERR_W-1:0]  err_q;
    logic signed [DATA_W-1:0] gts_q;
    logic signed [ACC_W-1:0]  p_q;

    logic signed [DATA_W-1:0] diff;
    logic signed [WIDE_W-1:0] gain_prod;
    logic signed [PROD_W-1:0] kp_x, gts_x, err_x;
    logic signed [PROD_W-1:0] p_prod, i_prod;
    logic signed [ACC_W-1:0]  om_x, sum;

    always_comb begin
        diff      = sp_q - act_q;
        gain_prod = WIDE_W'(ki_q) * WIDE_W'(per_q);
        kp_x      = PROD_W'(kp_q);
        gts_x     = PROD_W'(gts_q);
        err_x     = PROD_W'(err_q);
        p_prod    = kp_x * err_x;
        i_prod    = gts_x * err_x;
        om_x      = ACC_W'(om_q);
        sum       = p_q + integ + om_x;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q  <= '0;
            act_q <= '0;
            kp_q  <= '0;
            ki_q  <= '0;
            per_q <= '0;
            om_q  <= '0;
            err_q <= '0;
            gts_q <= '0;
            p_q   <= '0;
            inc   <= '0;
            y_out <= '0;
        end else begin
            if (accept) begin
                sp_q  <= setpoint;
                act_q <= actual;
                kp_q  <= kp;
                ki_q  <= ki;
                per_q <= period;
                om_q  <= omega_init;
            end
            if (en_err) begin
                err_q <= diff[ERR_W-1:0];
                gts_q <= DATA_W'(gain_prod >>> GAIN_SHIFT);
            end
            if (en_prod) begin
                p_q <= ACC_W'(p_prod >>> P_SHIFT);
                inc <= ACC_W'(i_prod >>> I_SHIFT);
            end
            if (en_emit) begin
                y_out <= DATA_W'(sum >>> OUT_SHIFT);
            end
        end
    end

    // captured operands stay frozen for the whole sequence
    assert_latch_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(sp_q) && $stable(act_q) && $stable(kp_q)
                                   && $stable(ki_q) && $stable(per_q) && $stable(om_q)));

endmodule

// File: rtl/pi_seq_ctrl.sv
module pi_seq_ctrl
    import pi_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ERR_W  = 24,
    parameter int unsigned ACC_W  = 48
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic signed [DATA_W-1:0] setpoint,
    input  logic signed [DATA_W-1:0] actual,
    input  logic signed [DATA_W-1:0] kp,
    input  logic signed [DATA_W-1:0] ki,
    input  logic signed [DATA_W-1:0] period,
    input  logic signed [DATA_W-1:0] omega_init,
    output logic signed [DATA_W-1:0] y_out,
    output logic                     done
);

    pi_state_t               state;
    logic                    accept, busy, en_err, en_prod, en_accum, en_emit;
    logic signed [ACC_W-1:0] inc, integ;

    pi_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .state    (state),
        .accept   (accept),
        .busy     (busy),
        .en_err   (en_err),
        .en_prod  (en_prod),
        .en_accum (en_accum),
        .en_emit  (en_emit),
        .done     (done)
    );

    pi_seq_datapath #(
        .DATA_W (DATA_W),
        .ERR_W  (ERR_W),
        .ACC_W  (ACC_W)
    ) u_dp (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .busy       (busy),
        .en_err     (en_err),
        .en_prod    (en_prod),
        .en_emit    (en_emit),
        .setpoint   (setpoint),
        .actual     (actual),
        .kp         (kp),
        .ki         (ki),
        .period     (period),
        .omega_init (omega_init),
        .integ      (integ),
        .inc        (inc),
        .y_out      (y_out)
    );

    pi_seq_integ #(
        .ACC_W (ACC_W)
    ) u_integ (
        .clk      (clk),
        .rst      (rst),
        .en_accum (en_accum),
        .inc      (inc),
        .integ    (integ)
    );

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_latency_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(accept, 5));

    assert_output_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(y_out) |-> done);

    assert_accum_once_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(integ) |-> (state == ST_EMIT));

    assert_state_legal_R8: assert property (@(posedge clk) disable iff (rst)
        state inside {ST_IDLE, ST_CALC_ERR, ST_CALC_PROD, ST_ACCUM, ST_EMIT, ST_FINISH});

endmodule

// File: tb/pi_seq_ctrl_tb.sv
module pi_seq_ctrl_tb;

    logic               clk = 1'b0;
    logic               rst;
    logic               start;
    logic signed [31:0] setpoint, actual, kp, ki, period, omega_init;
    logic signed [31:0] y_out;
    logic               done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic signed [47:0] integ_m;

    always #2 clk = ~clk;

    pi_seq_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .setpoint   (setpoint),
        .actual     (actual),
        .kp         (kp),
        .ki         (ki),
        .period     (period),
        .omega_init (omega_init),
        .y_out      (y_out),
        .done       (done)
    );

    task automatic check(input string req, input string what, input longint act_v, input longint exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
        end
    endtask

    // reference computed from the requirement formulas
    function automatic logic signed [31:0] model(
        input logic signed [31:0] sp, input logic signed [31:0] ac,
        input logic signed [31:0] kpv, input logic signed [31:0] kiv,
        input logic signed [31:0] tsv, input logic signed [31:0] omv);
        logic signed [63:0] d64, kt, pp, ii;
        logic signed [23:0] e;
        logic signed [31:0] g;
        logic signed [47:0] p48, i48, s48;
        d64 = longint'(sp) - longint'(ac);
        e   = d64[23:0];
        kt  = longint'(kiv) * longint'(tsv);
        kt  = kt >>> 21;
        g   = kt[31:0];
        pp  = longint'(kpv) * longint'(e);
        pp  = pp >>> 9;
        p48 = pp[47:0];
        ii  = longint'(g) * longint'(e);
        ii  = ii >>> 19;
        i48 = ii[47:0];
        integ_m = integ_m + i48;
        s48 = p48 + integ_m + 48'(omv);
        s48 = s48 >>> 8;
        return s48[31:0];
    endfunction

    // mode 0: plain; 1: operands change after accept; 2: extra start pulses while busy
    task automatic run_update(input string req, input int mode,
        input logic signed [31:0] sp, input logic signed [31:0] ac,
        input logic signed [31:0] kpv, input logic signed [31:0] kiv,
        input logic signed [31:0] tsv, input logic signed [31:0] omv);
        logic signed [31:0] exp_y;
        exp_y = model(sp, ac, kpv, kiv, tsv, omv);
        @(negedge clk);
        setpoint = sp; actual = ac; kp = kpv; ki = kiv; period = tsv; omega_init = omv;
        start = 1'b1;
        for (int n = 1; n <= 6; n++) begin
            @(negedge clk);
            start = 1'b0;
            if (mode == 1 && n == 1) begin
                setpoint = ~sp; actual = sp; kp = 32'sd7; ki = -kiv; period = 32'sd1; omega_init = ~omv;
            end
            if (mode == 2 && (n == 2 || n == 5)) start = 1'b1;
            if (n < 5)  check("R8", "done early", longint'(done), 0);
            if (n == 5) begin
                check("R8", "done pulse", longint'(done), 1);
                check(req, "y_out", longint'(y_out), longint'(exp_y));
            end
            if (n == 6) check("R8", "done width", longint'(done), 0);
        end
        start = 1'b0;
        if (mode == 2) begin
            for (int n = 0; n < 6; n++) begin
                @(negedge clk);
                check("R9", "no extra done", longint'(done), 0);
            end
            check("R9", "output unchanged", longint'(y_out), longint'(exp_y));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        integ_m = '0;
    endtask

    task automatic t_reset_state();
        check("R1", "done after reset", longint'(done), 0);
        check("R1", "y_out after reset", longint'(y_out), 0);
    endtask

    task automatic t_basic();
        // kp=1.0, ki=2.0, period=0.25, error=+3.0
        run_update("R5", 0, 32'sd16384, 32'sd4096, 32'sd2097152, 32'sd4194304, 32'sd536870912, 32'sd0);
    endtask

    task automatic t_negative_error();
        run_update("R7", 0, -32'sd5001, 32'sd3, 32'sd3145727, 32'sd1048577, 32'sd2147484, 32'sd77);
    endtask

    task automatic t_accumulate();
        for (int k = 0; k < 3; k++)
            run_update("R6", 0, 32'sd8192, 32'sd0, 32'sd0, 32'sd6291456, 32'sd1073741824, 32'sd0);
    endtask

    task automatic t_latch();
        run_update("R2", 1, 32'sd12000, -32'sd700, 32'sd1500000, 32'sd900000, 32'sd700000000, 32'sd4096);
    endtask

    task automatic t_busy_start();
        run_update("R9", 2, 32'sd2000, 32'sd100, 32'sd2097152, 32'sd2097152, 32'sd1073741824, 32'sd0);
        // next update exposes any extra integration
        run_update("R9", 0, 32'sd2000, 32'sd100, 32'sd2097152, 32'sd2097152, 32'sd1073741824, 32'sd0);
    endtask

    task automatic t_wrap();
        // difference of 0x900000 wraps to a negative 24-bit error
        run_update("R3", 0, 32'sh00900000, 32'sd0, 32'sd2097152, 32'sd0, 32'sd0, 32'sd0);
        run_update("R3", 0, 32'sh7FF00000, 32'sh80100000, 32'sd1234567, 32'sd0, 32'sd0, 32'sd0);
    endtask

    task automatic t_feedforward();
        run_update("R7", 0, 32'sd0, 32'sd0, 32'sd2097152, 32'sd2097152, 32'sd1073741824, 32'sh12345678);
        run_update("R7", 0, 32'sd0, 32'sd0, 32'sd0, 32'sd0, 32'sd0, -32'sd1000);
    endtask

    task automatic t_gain_scale();
        // large ki and period make the 64-bit product and truncation matter
        run_update("R4", 0, 32'sd409, 32'sd0, 32'sd0, 32'sh7FFFFFFF, 32'sh7FFFFFFF, 32'sd0);
        run_update("R4", 0, 32'sd409, 32'sd0, 32'sd0, -32'sd2147483647, 32'sd1999999999, 32'sd0);
    endtask

    task automatic t_reset_clears();
        run_update("R6", 0, 32'sd30000, 32'sd0, 32'sd0, 32'sd8388608, 32'sd1073741824, 32'sd0);
        do_reset();
        check("R1", "y_out cleared", longint'(y_out), 0);
        run_update("R10", 0, 32'sd4096, 32'sd0, 32'sd0, 32'sd2097152, 32'sd1073741824, 32'sd0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0;
        setpoint = '0; actual = '0; kp = '0; ki = '0; period = '0; omega_init = '0;
        integ_m = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_basic();
        t_negative_error();
        t_accumulate();
        t_latch();
        t_busy_start();
        t_wrap();
        t_feedforward();
        t_gain_scale();
        t_reset_clears();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule